// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block serialises one byte at a time onto an idle-high line. An 8-bit line control value sets the character format: 5 to 8 data bits sent least-significant bit first, an optional parity bit that can be odd, even, or fixed at 1 or 0, and a stop period of one, one and a half, or two bit times. Bytes are accepted through a valid/ready handshake. Timing comes from a one-cycle tick pulse supplied by an external baud divider, and each bit lasts a fixed number of ticks.

The format is captured when a byte is accepted, so software may change the control value while a character is on the line without corrupting that character. One control bit forces the line low to signal a break. The override acts on the output pin only: a character in flight keeps its internal timing, and when the break is released the line shows whatever that character is sending at that moment.

Top module: `sertx_top`

## Requirements
- R1: lcr_i[1:0] sets the data width (00=5, 01=6, 10=7, 11=8 bits). Data bits are sent least-significant bit first, straight after the start bit.
- R2: With lcr_i[3]=0 no parity bit is sent, whatever the values of lcr_i[5:4].
- R3: lcr_i[5:3]=001 sends a parity bit that makes the count of ones in data plus parity odd. 011 makes that count even.
- R4: lcr_i[5:3]=101 sends a parity bit fixed at 1, and 111 sends one fixed at 0.
- R5: With lcr_i[2]=0 the stop period is 16 ticks. With lcr_i[2]=1 it is 24 ticks for 5-bit words and 32 ticks for 6-, 7- and 8-bit words. The line is 1 throughout the stop period.
- R6: In the cycle after a byte is accepted, txd_o shows the start bit (0). Every start, data and parity bit lasts 16 ticks, and txd_o changes only in the cycle after a tick.
- R7: While lcr_i[6]=1, txd_o is 0, both when idle and during a frame. The frame's timing continues, and on release txd_o returns to the value the frame is currently sending.
- R8: The format in lcr_i[5:0] is sampled at acceptance. Changes made later have no effect on the frame in progress.
- R9: ready_o is 1 only when no frame is in progress, and valid_i is ignored while ready_o is 0. busy_o is high from acceptance until the tick that ends the stop period.
- R10: After reset, txd_o=1, ready_o=1 and busy_o=0. lcr_i[7] has no effect on the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lcr_i | input | 8 | Line control value (format and break) |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte offered |
| ready_o | output | 1 | Byte can be accepted (no frame in progress) |
| tick_i | input | 1 | One-cycle baud tick |
| busy_o | output | 1 | Frame in progress |
| txd_o | output | 1 | Serial line, idle high |

## Verification
The hardest case to reach from the ports is a break, or a change of the control value, that falls inside a frame while the tick spacing is irregular. Getting there needs the stimulus to track the frame position in ticks rather than in clock cycles. The bench counts ticks from acceptance and asserts or releases the break, and flips the format bits, at chosen tick indices. It also inserts random idle cycles between ticks, so a line change that is tied to the clock rather than to the tick is exposed. A byte is also offered while a frame is busy, and the bench then confirms that no second frame follows.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} sertx_state_e;
  typedef enum logic [1:0] {STOP_ONE, STOP_ONE_HALF, STOP_TWO} sertx_stop_e;
  typedef struct packed {
    logic [3:0]  nbits;
    logic        par_en;
    logic        par_bit;
    sertx_stop_e stop_sel;
  } sertx_fmt_t;
endpackage

// File: rtl/sertx_fmt.sv
`timescale 1ns/1ps
module sertx_fmt
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [7:0]        lcr_i,
  input  logic [DATA_W-1:0] data_i,
  output sertx_fmt_t        fmt_o
);
  logic [DATA_W-1:0] mask;
  logic              xor_d;

  always_comb begin
    fmt_o.nbits = 4'd5 + {2'b00, lcr_i[1:0]};
    for (int i = 0; i < DATA_W; i++) mask[i] = (i < int'(fmt_o.nbits));
    xor_d = ^(data_i & mask);
    fmt_o.par_en = lcr_i[3];
    // stick: 10 -> 1, 11 -> 0; else 00 odd, 01 even
    if (lcr_i[5]) fmt_o.par_bit = ~lcr_i[4];
    else          fmt_o.par_bit = lcr_i[4] ? xor_d : ~xor_d;
    if (!lcr_i[2])                 fmt_o.stop_sel = STOP_ONE;
    else if (lcr_i[1:0] == 2'b00)  fmt_o.stop_sel = STOP_ONE_HALF;
    else                           fmt_o.stop_sel = STOP_TWO;
  end
endmodule

// File: rtl/sertx_seq.sv
`timescale 1ns/1ps
module sertx_seq
  import sertx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  sertx_fmt_t        fmt_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              line_o,
  output logic              busy_o
);
  localparam int STOP_MAX = 2 * TICKS_PER_BIT;
  localparam int CNT_W    = $clog2(STOP_MAX);
  localparam int IDX_W    = $clog2(DATA_W);

  sertx_state_e      state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W:0]    phase_len;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q;
  sertx_fmt_t        fmt_q;
  logic              phase_end;

  always_comb begin
    phase_len = (CNT_W+1)'(TICKS_PER_BIT);
    if (state_q == ST_STOP) begin
      unique case (fmt_q.stop_sel)
        STOP_ONE_HALF: phase_len = (CNT_W+1)'(TICKS_PER_BIT + TICKS_PER_BIT/2);
        STOP_TWO:      phase_len = (CNT_W+1)'(STOP_MAX);
        default:       phase_len = (CNT_W+1)'(TICKS_PER_BIT);
      endcase
    end
  end

  assign phase_end = tick_i && ({1'b0, cnt_q} == phase_len - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      fmt_q   <= '0;
    end else if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_q <= ST_START;
        cnt_q   <= '0;
        idx_q   <= '0;
        shreg_q <= data_i;
        fmt_q   <= fmt_i;
      end
    end else if (tick_i) begin
      if (phase_end) begin
        cnt_q <= '0;
        unique case (state_q)
          ST_START: state_q <= ST_DATA;
          ST_DATA: begin
            shreg_q <= shreg_q >> 1;
            idx_q   <= idx_q + 1'b1;
            if ({1'b0, idx_q} == IDX_W'(fmt_q.nbits - 4'd1))
              state_q <= fmt_q.par_en ? ST_PAR : ST_STOP;
          end
          ST_PAR:  state_q <= ST_STOP;
          default: state_q <= ST_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (state_q)
      ST_START: line_o = 1'b0;
      ST_DATA:  line_o = shreg_q[0];
      ST_PAR:   line_o = fmt_q.par_bit;
      default:  line_o = 1'b1;
    endcase
  end

  assign busy_o = (state_q != ST_IDLE);

  assert_start_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !line_o);
  assert_hold_between_ticks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !tick_i |=> $stable(line_o));
  assert_end_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tick_i));
  assert_fmt_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(fmt_q));
  assert_no_start_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
endmodule

// File: rtl/sertx_top.sv
`timescale 1ns/1ps
module sertx_top
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] lcr_i,
  input  logic [7:0] data_i,
  input  logic       valid_i,
  output logic       ready_o,
  input  logic       tick_i,
  output logic       busy_o,
  output logic       txd_o
);
  localparam int DATA_W = 8;

  sertx_fmt_t fmt;
  logic       line;
  logic       accept;

  sertx_fmt #(.DATA_W(DATA_W)) i_fmt (
    .lcr_i (lcr_i),
    .data_i(data_i),
    .fmt_o (fmt)
  );

  assign accept = valid_i && ready_o;

  sertx_seq #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .start_i(accept),
    .fmt_i  (fmt),
    .data_i (data_i),
    .line_o (line),
    .busy_o (busy_o)
  );

  assign ready_o = !busy_o;
  // break acts on the pin only; frame timing runs on
  assign txd_o   = line && !lcr_i[6];

  assert_idle_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !lcr_i[6] |-> txd_o);
endmodule

// File: tb/test_sertx_top.sv
`timescale 1ns/1ps
module test_sertx_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] lcr_i = 8'h03;
  logic [7:0] data_i = 8'h00;
  logic       valid_i = 1'b0;
  logic       tick_i = 1'b0;
  logic       ready_o, busy_o, txd_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  sertx_top i_sertx_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .lcr_i(lcr_i), .data_i(data_i),
    .valid_i(valid_i), .ready_o(ready_o), .tick_i(tick_i),
    .busy_o(busy_o), .txd_o(txd_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nbits_of(input logic [7:0] l);
    return 5 + int'(l[1:0]);
  endfunction

  function automatic bit par_of(input logic [7:0] l, input logic [7:0] d);
    logic x = 1'b0;
    for (int i = 0; i < nbits_of(l); i++) x ^= d[i];
    case (l[5:4])
      2'b00:   return ~x;
      2'b01:   return x;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int total_ticks(input logic [7:0] l);
    int stop_t = !l[2] ? 16 : (nbits_of(l) == 5 ? 24 : 32);
    return 16 * (1 + nbits_of(l) + int'(l[3])) + stop_t;
  endfunction

  function automatic bit exp_bit(input logic [7:0] l, input logic [7:0] d, input int j);
    int k;
    if (j < 16) return 1'b0;
    k = j / 16 - 1;
    if (k < nbits_of(l)) return d[k];
    if (l[3] && k == nbits_of(l)) return par_of(l, d);
    return 1'b1;
  endfunction

  function automatic string req_of(input logic [7:0] l, input int j);
    int k = j / 16 - 1;
    if (j < 16) return "R6";
    if (k < nbits_of(l)) return "R1";
    if (k == nbits_of(l) && l[3]) return (l[5] ? "R4" : "R3");
    return "R5";
  endfunction

  // brk_lo..brk_hi: tick window with break; chg_at: tick index to scramble format
  task automatic send(input logic [7:0] l, input logic [7:0] d, input int max_gap,
                      input int brk_lo, input int brk_hi, input int chg_at, input bit poke);
    int tot = total_ticks(l);
    bit brk;
    @(negedge clk_i);
    chk(ready_o == 1'b1, "R9", ready_o, 1);
    lcr_i = l; data_i = d; valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0; data_i = ~d;
    chk(busy_o == 1'b1 && ready_o == 1'b0, "R9", busy_o, 1);
    for (int j = 0; j < tot; j++) begin
      brk = (j >= brk_lo && j < brk_hi);
      lcr_i[6] = brk;
      if (j == chg_at) lcr_i[5:0] = ~l[5:0];
      #0.5;
      if (brk) chk(txd_o == 1'b0, "R7", txd_o, 0);
      else chk(txd_o == exp_bit(l, d, j), req_of(l, j), txd_o, exp_bit(l, d, j));
      if (poke && j == 20) begin
        chk(ready_o == 1'b0, "R9", ready_o, 0);
        valid_i = 1'b1; data_i = 8'h00;
      end
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0; valid_i = 1'b0;
      repeat ($urandom_range(max_gap, 0)) @(negedge clk_i);
    end
    lcr_i = l & 8'hBF;
    #0.5;
    chk(busy_o == 1'b0 && ready_o == 1'b1, "R5", busy_o, 0);
    chk(txd_o == 1'b1, "R5", txd_o, 1);
    if (poke) begin
      for (int j = 0; j < 20; j++) begin
        tick_i = 1'b1; @(negedge clk_i); tick_i = 1'b0; #0.5;
        chk(txd_o == 1'b1 && busy_o == 1'b0, "R9", txd_o, 1);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    #1;
    chk(txd_o == 1'b1, "R10", txd_o, 1);
    chk(ready_o == 1'b1 && busy_o == 1'b0, "R10", busy_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #0.5;
    chk(txd_o == 1'b1 && ready_o == 1'b1, "R10", txd_o, 1);

    // R1 word lengths, R2 parity off with stick bits set
    send(8'b0011_0000, 8'hA5, 0, -1, -1, -1, 0);
    send(8'b0011_0001, 8'h5A, 1, -1, -1, -1, 0);
    send(8'b0010_0010, 8'hC3, 0, -1, -1, -1, 0);
    send(8'b0000_0011, 8'h96, 2, -1, -1, -1, 0);
    // R3 odd/even, R4 stick 1/0
    send(8'b0000_1011, 8'h01, 0, -1, -1, -1, 0);
    send(8'b0001_1011, 8'h01, 0, -1, -1, -1, 0);
    send(8'b0000_1000, 8'h1F, 1, -1, -1, -1, 0);
    send(8'b0010_1010, 8'h00, 0, -1, -1, -1, 0);
    send(8'b0011_1001, 8'hFF, 0, -1, -1, -1, 0);
    // R5 stop lengths: 1.5 with 5 bits, 2 with 6 and 8
    send(8'b0000_0100, 8'h15, 0, -1, -1, -1, 0);
    send(8'b0000_1100, 8'h0A, 1, -1, -1, -1, 0);
    send(8'b0000_0101, 8'h2B, 0, -1, -1, -1, 0);
    send(8'b0001_1111, 8'h7E, 2, -1, -1, -1, 0);
    // R7 break inside frame and reaching stop
    send(8'b0000_1011, 8'hFF, 1, 20, 70, -1, 0);
    send(8'b0000_0111, 8'hAA, 0, 150, 200, -1, 0);
    // R8 format change mid-frame, R10 lcr_i[7] set
    send(8'b1000_1011, 8'h3C, 1, -1, -1, 10, 0);
    send(8'b0001_1100, 8'h13, 0, -1, -1, 5, 0);
    // R9 offer while busy is ignored
    send(8'b0000_0011, 8'h81, 1, -1, -1, -1, 1);

    // R7 break while idle
    @(negedge clk_i);
    lcr_i = 8'h43; #0.5;
    chk(txd_o == 1'b0 && ready_o == 1'b1, "R7", txd_o, 0);
    @(negedge clk_i);
    lcr_i = 8'h03; #0.5;
    chk(txd_o == 1'b1, "R7", txd_o, 1);

    for (int n = 0; n < 40; n++) begin
      logic [7:0] l = 8'($urandom) & 8'hBF;
      logic [7:0] d = 8'($urandom);
      int b = ($urandom_range(3, 0) == 0) ? int'($urandom_range(120, 0)) : -1;
      int c = ($urandom_range(2, 0) == 0) ? int'($urandom_range(100, 0)) : -1;
      send(l, d, 3, b, b + 25, c, (n % 10) == 3);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule